// File: doc/BRIEF.md
# Serial Shift Core with Selectable Clock Source

This block is an 8-bit serial shift register with a 4-bit transfer counter. The shift register and the counter can be clocked from the same source or from different ones. A 2-bit source code picks the register clock. It can be no clock, a software strobe bit, a timer compare pulse, or an external serial clock pin. For the pin, either its rising or its falling edge is used. Data leaves most significant bit first on a serial output. Each new bit enters at bit 0, and it is the serial input value captured one clock earlier.

A control write carries four fields together: the source code, a strobe bit, a toggle bit and, implicitly, the write itself. When the source is external, the strobe bit stops acting as a strobe. It is then stored as a counter clock select, and with it set the counter advances only on control writes that carry the toggle bit. The toggle bit also inverts a serial clock output latch, so a master can drive its own clock. The counter wraps and raises a sticky overflow flag. A second sticky flag records any edge on the clock pin.

Top module: `ser_shift_core`

## Requirements
- R1: With `rst` high at a clock edge, the data register, the counter, the overflow flag, the edge flag, the clock output latch, the source code and the counter clock select all become 0.
- R2: With source code 0, neither the register nor the counter moves unless a control write has `ctl_sel`=0 and `ctl_strobe`=1. Such a write shifts the register once and adds one to the counter, both visible right after that clock edge.
- R3: A shift moves the register left by one. `ser_out` is bit 7. The bit entering at bit 0 is the `ser_in` value sampled at the clock edge before the shifting edge.
- R4: With stored source code 1, each cycle with `tmr_match` high shifts the register once and adds one to the counter.
- R5: `sck_in` passes two synchronizer flops. With stored source code 2 the register shifts on a rising pin edge, and with code 3 on a falling edge. The shift is visible after the third clock edge that follows the pin change.
- R6: With an external source (code 2 or 3) and the stored counter clock select at 0, the counter adds one on every synchronized edge of `sck_in`, rising or falling.
- R7: Every control write stores `ctl_strobe` as the counter clock select. With an external source and the select at 1, pin edges no longer move the counter. The counter then adds one only on a control write that has `ctl_sel`[1]=1, `ctl_strobe`=1 and `ctl_toggle`=1.
- R8: Every control write with `ctl_toggle`=1 inverts `sck_out`, whatever the source code.
- R9: `ctl_rd` returns {source code, 0, 0`}`. The strobe and toggle positions always read 0.
- R10: The counter wraps from 15 to 0, and that wrap sets `cnt_ovf`. `ovf_clr` clears the flag. If a wrap and a clear happen in the same cycle, the flag is set.
- R11: `edge_flag` is set on any synchronized edge of `sck_in`, in every mode. `edge_clr` clears it. If an edge and a clear happen in the same cycle, the flag is set.
- R12: `dat_wr` loads `dat_wdata` into the register and wins over a shift in the same cycle. The counter still counts that cycle's tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write enable |
| ctl_sel | input | 2 | Source code written |
| ctl_strobe | input | 1 | Strobe bit, or counter clock select in external mode |
| ctl_toggle | input | 1 | Clock output toggle bit |
| ctl_rd | output | 4 | Control readback |
| dat_wr | input | 1 | Data register load |
| dat_wdata | input | 8 | Data to load |
| dat_rd | output | 8 | Data register contents |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output (bit 7) |
| sck_in | input | 1 | External serial clock pin |
| sck_out | output | 1 | Serial clock output latch |
| tmr_match | input | 1 | Timer compare pulse |
| cnt_val | output | 4 | Transfer counter value |
| cnt_ovf | output | 1 | Sticky counter wrap flag |
| ovf_clr | input | 1 | Clears the wrap flag |
| edge_flag | output | 1 | Sticky clock pin edge flag |
| edge_clr | input | 1 | Clears the edge flag |

## Verification
The bench aims at the exact clock edge on which a pin edge takes effect. A synchronizer one flop short or long would shift a cycle early or late and break the per-cycle comparison. It checks that the shifted bit is the input from one cycle earlier: a design that samples the live input would insert the wrong bit after every input change. It drives the external mode with the counter clock select set. A design that still counted pin edges, or that ignored the toggle writes, would show a wrong counter value. It also checks that a load wins over a shift in the same cycle, that the sticky flags survive a clear arriving together with a set, and that the one-cycle pulse bits never read back as 1.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_TIMER    = 2'd1,
        SRC_EXT_RISE = 2'd2,
        SRC_EXT_FALL = 2'd3
    } src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic shift;
        logic count;
    } tick_t;

    typedef struct packed {
        src_e src;
        logic cnt_by_toggle;
    } ctl_t;

    function automatic logic src_is_ext(src_e s);
        return s[1];
    endfunction

    function automatic logic any_edge(edge_t e);
        return e.rise | e.fall;
    endfunction

endpackage

// File: rtl/ssu_sync_edge.sv
module ssu_sync_edge
    import ssu_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin,
    output edge_t edg
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        edg.rise = chain_q[STAGES-1] & ~chain_q[STAGES];
        edg.fall = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

    assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
        edg.rise |=> !edg.rise);
    assert_fall_single_R5: assert property (@(posedge clk) disable iff (rst)
        edg.fall |=> !edg.fall);

endmodule

// File: rtl/ssu_clk_route.sv
module ssu_clk_route
    import ssu_pkg::*;
(
    input  ctl_t       ctl_q,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_sel,
    input  logic       ctl_strobe,
    input  logic       ctl_toggle,
    input  logic       tmr_match,
    input  edge_t      edg,
    output tick_t      tk
);
    logic sw_strobe;
    logic sw_toggle_cnt;
    logic ext_shift;
    logic ext_count;

    always_comb begin
        sw_strobe     = ctl_wr && ctl_strobe && (src_e'(ctl_sel) == SRC_NONE);
        sw_toggle_cnt = ctl_wr && ctl_toggle && ctl_strobe && ctl_sel[1];
        ext_shift = 1'b0;
        case (ctl_q.src)
            SRC_EXT_RISE: ext_shift = edg.rise;
            SRC_EXT_FALL: ext_shift = edg.fall;
            default:      ext_shift = 1'b0;
        endcase
        ext_count = src_is_ext(ctl_q.src) && !ctl_q.cnt_by_toggle && any_edge(edg);

        tk.shift = sw_strobe
                 || ((ctl_q.src == SRC_TIMER) && tmr_match)
                 || ext_shift;
        tk.count = sw_strobe
                 || ((ctl_q.src == SRC_TIMER) && tmr_match)
                 || ext_count
                 || sw_toggle_cnt;
    end

endmodule

// File: rtl/ssu_counter.sv
module ssu_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic wrap;

    assign wrap = inc && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            if (inc) cnt <= cnt + CNT_ONE;
            if (wrap)     ovf <= 1'b1;
            else if (clr) ovf <= 1'b0;
        end
    end

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
        inc |=> (cnt == $past(cnt) + CNT_ONE));
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt));
    assert_ovf_set_R10: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt == CNT_MAX) |=> (ovf && cnt == '0));
    assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (clr && !(inc && cnt == CNT_MAX)) |=> !ovf);

endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core
    import ssu_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [1:0]        ctl_sel,
    input  logic              ctl_strobe,
    input  logic              ctl_toggle,
    output logic [3:0]        ctl_rd,
    input  logic              dat_wr,
    input  logic [DATA_W-1:0] dat_wdata,
    output logic [DATA_W-1:0] dat_rd,
    input  logic              ser_in,
    output logic              ser_out,
    input  logic              sck_in,
    output logic              sck_out,
    input  logic              tmr_match,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              cnt_ovf,
    input  logic              ovf_clr,
    output logic              edge_flag,
    input  logic              edge_clr
);
    localparam int unsigned MSB = DATA_W - 1;

    ctl_t              ctl_q;
    logic [DATA_W-1:0] shreg_q;
    logic              din_q;
    logic              sck_q;
    logic              eflag_q;
    edge_t             edg;
    tick_t             tk;

    ssu_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (sck_in),
        .edg (edg)
    );

    ssu_clk_route u_route (
        .ctl_q      (ctl_q),
        .ctl_wr     (ctl_wr),
        .ctl_sel    (ctl_sel),
        .ctl_strobe (ctl_strobe),
        .ctl_toggle (ctl_toggle),
        .tmr_match  (tmr_match),
        .edg        (edg),
        .tk         (tk)
    );

    ssu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (tk.count),
        .clr (ovf_clr),
        .cnt (cnt_val),
        .ovf (cnt_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '{src: SRC_NONE, cnt_by_toggle: 1'b0};
            shreg_q <= '0;
            din_q   <= 1'b0;
            sck_q   <= 1'b0;
            eflag_q <= 1'b0;
        end else begin
            din_q <= ser_in;
            if (ctl_wr) begin
                ctl_q.src           <= src_e'(ctl_sel);
                ctl_q.cnt_by_toggle <= ctl_strobe;
                if (ctl_toggle) sck_q <= ~sck_q;
            end
            if (dat_wr)        shreg_q <= dat_wdata;
            else if (tk.shift) shreg_q <= {shreg_q[MSB-1:0], din_q};
            if (any_edge(edg))  eflag_q <= 1'b1;
            else if (edge_clr)  eflag_q <= 1'b0;
        end
    end

    assign ctl_rd    = {ctl_q.src, 2'b00};
    assign dat_rd    = shreg_q;
    assign ser_out   = shreg_q[MSB];
    assign sck_out   = sck_q;
    assign edge_flag = eflag_q;

    assert_sck_toggle_R8: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_toggle) |=> (sck_out != $past(sck_out)));
    assert_sck_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(ctl_wr && ctl_toggle) |=> $stable(sck_out));
    assert_shift_out_R3: assert property (@(posedge clk) disable iff (rst)
        (tk.shift && !dat_wr) |=> (ser_out == $past(shreg_q[MSB-1])));
    assert_load_wins_R12: assert property (@(posedge clk) disable iff (rst)
        dat_wr |=> (dat_rd == $past(dat_wdata)));
    assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.src == SRC_NONE && !ctl_wr && !dat_wr) |=> $stable(dat_rd));
    assert_edge_flag_R11: assert property (@(posedge clk) disable iff (rst)
        any_edge(edg) |=> edge_flag);

endmodule

// File: tb/ser_shift_core_test.sv
`timescale 1ns/1ps
module ser_shift_core_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       ctl_wr, ctl_strobe, ctl_toggle;
    logic [1:0] ctl_sel;
    logic [3:0] ctl_rd;
    logic       dat_wr;
    logic [7:0] dat_wdata, dat_rd;
    logic       ser_in, ser_out, sck_in, sck_out, tmr_match;
    logic [3:0] cnt_val;
    logic       cnt_ovf, ovf_clr, edge_flag, edge_clr;

    always #2.5 clk = ~clk;

    ser_shift_core uut (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_sel(ctl_sel), .ctl_strobe(ctl_strobe),
        .ctl_toggle(ctl_toggle), .ctl_rd(ctl_rd),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
        .ser_in(ser_in), .ser_out(ser_out),
        .sck_in(sck_in), .sck_out(sck_out), .tmr_match(tmr_match),
        .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .ovf_clr(ovf_clr),
        .edge_flag(edge_flag), .edge_clr(edge_clr)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // reference state, derived from the requirements
    logic [7:0] m_reg;
    logic [3:0] m_cnt;
    logic [1:0] m_sel;
    logic       m_csel, m_ovf, m_sck, m_eflag, m_din, m_s1, m_s2, m_s3;

    function automatic logic [7:0] shl(logic [7:0] v, logic b);
        return {v[6:0], b};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_reg = 0; m_cnt = 0; m_sel = 0; m_csel = 0; m_ovf = 0;
        m_sck = 0; m_eflag = 0; m_din = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    endtask

    task automatic model_step();
        logic rise, fall, sw, sh, cn;
        rise = m_s2 & ~m_s3;
        fall = ~m_s2 & m_s3;
        sw   = ctl_wr && ctl_strobe && ctl_sel == 2'd0;
        sh   = sw || (m_sel == 2'd1 && tmr_match)
                  || (m_sel == 2'd2 && rise) || (m_sel == 2'd3 && fall);
        cn   = sw || (m_sel == 2'd1 && tmr_match)
                  || (m_sel[1] && !m_csel && (rise || fall))
                  || (ctl_wr && ctl_toggle && ctl_strobe && ctl_sel[1]);
        if (dat_wr)  m_reg = dat_wdata;
        else if (sh) m_reg = shl(m_reg, m_din);
        if (cn && m_cnt == 4'hF) m_ovf = 1'b1;
        else if (ovf_clr)        m_ovf = 1'b0;
        if (cn) m_cnt = m_cnt + 4'd1;
        if (rise || fall)  m_eflag = 1'b1;
        else if (edge_clr) m_eflag = 1'b0;
        if (ctl_wr) begin
            m_sel  = ctl_sel;
            m_csel = ctl_strobe;
            if (ctl_toggle) m_sck = ~m_sck;
        end
        m_din = ser_in;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = sck_in;
    endtask

    task automatic compare_all();
        chk("R3 dat_rd",    dat_rd,    m_reg);
        chk("R3 ser_out",   ser_out,   m_reg[7]);
        chk("R6 cnt_val",   cnt_val,   m_cnt);
        chk("R10 cnt_ovf",  cnt_ovf,   m_ovf);
        chk("R8 sck_out",   sck_out,   m_sck);
        chk("R11 edge_flag", edge_flag, m_eflag);
        chk("R9 ctl_rd",    ctl_rd,    {m_sel, 2'b00});
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) model_reset(); else model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        ctl_wr = 0; ctl_sel = 0; ctl_strobe = 0; ctl_toggle = 0;
        dat_wr = 0; dat_wdata = 0; tmr_match = 0; ovf_clr = 0; edge_clr = 0;
    endtask

    task automatic ctl_write(logic [1:0] s, logic st, logic tg);
        ctl_wr = 1; ctl_sel = s; ctl_strobe = st; ctl_toggle = tg;
        tick();
        ctl_wr = 0; ctl_strobe = 0; ctl_toggle = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        idle_inputs();
        ser_in = 0; sck_in = 0; rst = 1;
        model_reset();
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 dat_rd", dat_rd, 0);
        chk("R1 cnt_val", cnt_val, 0);
        chk("R1 flags", {cnt_ovf, edge_flag, sck_out}, 0);
        chk("R1 ctl_rd", ctl_rd, 0);

        // R2 no clock without strobe
        ser_in = 1;
        ctl_write(2'd0, 1'b0, 1'b0);
        repeat (4) tick();
        chk("R2 idle count", cnt_val, 0);
        chk("R2 idle data", dat_rd, 0);
        ctl_write(2'd0, 1'b1, 1'b0);
        chk("R2 strobe count", cnt_val, 1);
        chk("R3 strobe data", dat_rd, 8'h01);

        // R12 load wins over a strobe shift, counter still counts
        dat_wr = 1; dat_wdata = 8'hA5;
        ctl_write(2'd0, 1'b1, 1'b0);
        dat_wr = 0;
        chk("R12 load wins", dat_rd, 8'hA5);
        chk("R12 count", cnt_val, 2);

        // R4 timer source
        ser_in = 0;
        ctl_write(2'd1, 1'b0, 1'b0);
        tmr_match = 1;
        repeat (3) tick();
        tmr_match = 0;
        chk("R4 timer data", dat_rd, 8'h28);
        chk("R4 timer count", cnt_val, 5);

        // R5 rising edge source with three-edge latency
        ser_in = 1;
        ctl_write(2'd2, 1'b0, 1'b0);
        sck_in = 1;
        repeat (2) tick();
        chk("R5 not yet", dat_rd, 8'h28);
        tick();
        chk("R5 rise shift", dat_rd, 8'h51);
        chk("R6 rise count", cnt_val, 6);
        sck_in = 0;
        repeat (3) tick();
        chk("R5 fall ignored", dat_rd, 8'h51);
        chk("R6 fall count", cnt_val, 7);
        ctl_write(2'd3, 1'b0, 1'b0);
        sck_in = 1;
        repeat (3) tick();
        chk("R5 rise ignored", dat_rd, 8'h51);
        sck_in = 0;
        repeat (3) tick();
        chk("R5 fall shift", dat_rd, 8'hA3);
        chk("R6 both edges", cnt_val, 9);

        // R7 counter clocked by toggle writes only
        ctl_write(2'd2, 1'b1, 1'b0);
        sck_in = 1;
        repeat (3) tick();
        chk("R7 shift still", dat_rd, 8'h47);
        chk("R7 edge not counted", cnt_val, 9);
        ctl_write(2'd2, 1'b1, 1'b1);
        chk("R7 toggle counts", cnt_val, 10);
        chk("R8 toggled", sck_out, 1);
        chk("R9 readback", ctl_rd, 4'b1000);

        // R10 wrap and sticky flag
        repeat (6) ctl_write(2'd2, 1'b1, 1'b1);
        chk("R10 wrap value", cnt_val, 0);
        chk("R10 wrap flag", cnt_ovf, 1);
        ovf_clr = 1; tick(); ovf_clr = 0;
        chk("R10 cleared", cnt_ovf, 0);

        // R11 edge flag clear
        chk("R11 flag set", edge_flag, 1);
        edge_clr = 1; tick(); edge_clr = 0;
        chk("R11 cleared", edge_flag, 0);

        // random phase against the reference
        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            ctl_wr     = (r[2:0] == 3'd0);
            ctl_sel    = r[4:3];
            ctl_strobe = r[5];
            ctl_toggle = r[6];
            dat_wr     = (r[11:7] == 5'd0);
            dat_wdata  = r[19:12];
            tmr_match  = (r[21:20] == 2'd0);
            ser_in     = r[22];
            if (r[25:23] == 3'd0) sck_in = ~sck_in;
            ovf_clr    = (r[28:26] == 3'd0);
            edge_clr   = (r[31:29] == 3'd0);
            tick();
        end
        idle_inputs();
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule